// File: doc/BRIEF.md
# SPI Receive Buffer with Burst DMA Requests

This block is the receive-side store of a serial peripheral. It sits between the receive shifter and the bus-visible data register. Each received word arrives as a one-cycle strobe with its data, and the block keeps it until the data register is read. The same eight bytes of storage are viewed either as eight 8-bit entries or as four 16-bit entries, depending on the word-length input. With the FIFO-enable input low, the block is a single-entry holding register.

A receive DMA request is raised for as long as receive DMA is enabled and at least one entry is waiting. One DMA service can therefore drain a whole burst of reads, up to the full content, before the request drops. The DMA engine decides how many items it moves. When the buffer is empty the request falls, so the count of requests shrinks as the burst size grows. A word that arrives while the buffer is full is dropped and a sticky overrun flag is raised. A change of word length or of FIFO enable empties the buffer.

Top module: `spi_rx_buffer`

## Requirements
- R1: After reset, level_o is 0, empty_o is 1, and full_o, overrun_o, dma_req_o and rd_data_o are all 0.
- R2: With fifo_en_i=1 and wide_i=0, up to 8 bytes (rx_data_i[7:0]) are kept and read back in arrival order. full_o is 1 exactly when level_o is 8.
- R3: With fifo_en_i=1 and wide_i=1, up to 4 16-bit words are kept and read back in arrival order. full_o is 1 exactly when level_o is 4.
- R4: With fifo_en_i=0, the capacity is one entry and full_o is 1 whenever level_o is 1.
- R5: A read strobe rd_i on a non-empty buffer removes the oldest entry and places it on rd_data_o one clock later. In 8-bit mode rd_data_o[15:8] is 0.
- R6: A receive strobe while full_o is 1, with no read in the same cycle, is discarded: level and contents are unchanged and overrun_o is set. overrun_o stays set until ovr_clr_i is pulsed or a flush occurs. A set in the same cycle wins over a clear.
- R7: When full, a receive and a read in the same cycle both take effect: the level stays the same and no overrun is raised.
- R8: A read strobe on an empty buffer leaves rd_data_o at its last value and leaves level_o at 0.
- R9: dma_req_o is 1 exactly when dma_en_i is 1 and level_o is non-zero, so it stays high across a burst of reads and falls when the buffer empties.
- R10: A cycle in which wide_i or fifo_en_i differs from its value in the previous cycle flushes the buffer. On the next clock level_o is 0 and overrun_o is 0, and a receive or read in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| fifo_en_i | input | 1 | 1: multi-entry FIFO, 0: single-entry buffer |
| wide_i | input | 1 | 1: 16-bit entries, 0: 8-bit entries |
| dma_en_i | input | 1 | Receive DMA enable |
| rx_valid_i | input | 1 | Received-word strobe from the shifter |
| rx_data_i | input | 16 | Received word; only bits 7:0 used in 8-bit mode |
| rd_i | input | 1 | Data-register read strobe (CPU or DMA) |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_data_o | output | 16 | Last entry read |
| level_o | output | LVL_W | Entries held |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | Level has reached the mode's capacity |
| overrun_o | output | 1 | Sticky flag: a word was dropped |
| dma_req_o | output | 1 | Receive DMA request |

## Verification
Directed sequences fill each of the three capacity modes exactly to full and one past, then drain them. This tells a wrong capacity or a swapped byte order apart from a correct one, and the 8-bit drain shows whether the upper data byte is masked. Simultaneous receive-and-read at full and reads of an empty buffer probe the edges of the pointer logic. Mode toggles with data still held separate a real flush from a pointer reset that leaves the level or the overrun flag behind. A long seeded random stream then mixes all inputs and occasional mode changes, comparing every cycle against a queue model kept in the bench.

// File: rtl/spi_rxb_pkg.sv
package spi_rxb_pkg;

    localparam int RXB_BYTES = 8;

    typedef enum logic {
        WL_BYTE = 1'b0,
        WL_HALF = 1'b1
    } wlen_e;

    // Entries the buffer may hold for a given configuration.
    function automatic int cap_entries(input logic fen, input logic wide, input int bytes);
        if (!fen)
            return 1;
        return (wide == WL_HALF) ? bytes / 2 : bytes;
    endfunction

endpackage

// File: rtl/spi_rxb_cap.sv
module spi_rxb_cap #(
    parameter int BYTES = spi_rxb_pkg::RXB_BYTES,
    parameter int LVL_W = $clog2(BYTES) + 1
) (
    input  logic             fifo_en_i,
    input  logic             wide_i,
    output logic [LVL_W-1:0] cap_o
);
    always_comb begin
        cap_o = LVL_W'(spi_rxb_pkg::cap_entries(fifo_en_i, wide_i, BYTES));
    end
endmodule

// File: rtl/spi_rxb_store.sv
module spi_rxb_store #(
    parameter int BYTES = spi_rxb_pkg::RXB_BYTES,
    parameter int PTR_W = $clog2(BYTES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             wide_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [15:0]      wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [15:0]      rdata_o
);
    logic [7:0]       lane_w [BYTES];
    logic [PTR_W-1:0] waddr_hi;
    logic [PTR_W-1:0] raddr_hi;

    assign waddr_hi = waddr_i + PTR_W'(1);
    assign raddr_hi = raddr_i + PTR_W'(1);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                lane_q <= '0;
            else if (we_i && waddr_i == PTR_W'(g))
                lane_q <= wdata_i[7:0];
            else if (we_i && wide_i && waddr_hi == PTR_W'(g))
                lane_q <= wdata_i[15:8];
        end
        assign lane_w[g] = lane_q;
    end

    assign rdata_o = {wide_i ? lane_w[raddr_hi] : 8'h00, lane_w[raddr_i]};
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer #(
    parameter int BYTES = spi_rxb_pkg::RXB_BYTES,
    parameter int LVL_W = $clog2(BYTES) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fifo_en_i,
    input  logic             wide_i,
    input  logic             dma_en_i,
    input  logic             rx_valid_i,
    input  logic [15:0]      rx_data_i,
    input  logic             rd_i,
    input  logic             ovr_clr_i,
    output logic [15:0]      rd_data_o,
    output logic [LVL_W-1:0] level_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             overrun_o,
    output logic             dma_req_o
);
    localparam int PTR_W = $clog2(BYTES);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] count;
        logic             ovr;
        logic             fen;
        logic             wide;
        logic [15:0]      rdata;
    } state_t;

    state_t           s_d, s_q;
    logic [LVL_W-1:0] cap;
    logic [15:0]      head;
    logic             flush, pop, push;
    logic [PTR_W-1:0] step;

    spi_rxb_cap #(.BYTES(BYTES), .LVL_W(LVL_W)) cap_i (
        .fifo_en_i (fifo_en_i),
        .wide_i    (wide_i),
        .cap_o     (cap)
    );

    spi_rxb_store #(.BYTES(BYTES), .PTR_W(PTR_W)) store_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (push),
        .wide_i  (wide_i),
        .waddr_i (s_q.wr_ptr),
        .wdata_i (rx_data_i),
        .raddr_i (s_q.rd_ptr),
        .rdata_o (head)
    );

    always_comb begin
        s_d   = s_q;
        step  = wide_i ? PTR_W'(2) : PTR_W'(1);
        flush = (wide_i != s_q.wide) || (fifo_en_i != s_q.fen);
        pop   = rd_i && (s_q.count != '0) && !flush;
        push  = rx_valid_i && !flush && ((s_q.count < cap) || pop);

        s_d.fen  = fifo_en_i;
        s_d.wide = wide_i;

        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.count  = '0;
            s_d.ovr    = 1'b0;
        end else begin
            if (pop) begin
                s_d.rd_ptr = s_q.rd_ptr + step;
                s_d.rdata  = head;
            end
            if (push)
                s_d.wr_ptr = s_q.wr_ptr + step;
            case ({push, pop})
                2'b10:   s_d.count = s_q.count + LVL_W'(1);
                2'b01:   s_d.count = s_q.count - LVL_W'(1);
                default: s_d.count = s_q.count;
            endcase
            if (ovr_clr_i)
                s_d.ovr = 1'b0;
            if (rx_valid_i && !push)
                s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign rd_data_o = s_q.rdata;
    assign level_o   = s_q.count;
    assign empty_o   = (s_q.count == '0);
    assign full_o    = (s_q.count >= cap);
    assign overrun_o = s_q.ovr;
    assign dma_req_o = dma_en_i && (s_q.count != '0);
endmodule

// File: rtl/spi_rxb_checker.sv
module spi_rxb_checker #(
    parameter int BYTES = spi_rxb_pkg::RXB_BYTES,
    parameter int LVL_W = $clog2(BYTES) + 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fifo_en_i,
    input logic             wide_i,
    input logic             rx_valid_i,
    input logic             rd_i,
    input logic             ovr_clr_i,
    input logic [15:0]      rd_data_o,
    input logic [LVL_W-1:0] level_o,
    input logic             empty_o,
    input logic             full_o,
    input logic             overrun_o,
    input logic             dma_req_o
);
    logic fen_seen, wide_seen, mode_chg;
    int   cap_now;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fen_seen  <= 1'b0;
            wide_seen <= 1'b0;
        end else begin
            fen_seen  <= fifo_en_i;
            wide_seen <= wide_i;
        end
    end

    assign mode_chg = (fen_seen != fifo_en_i) || (wide_seen != wide_i);
    assign cap_now  = spi_rxb_pkg::cap_entries(fifo_en_i, wide_i, BYTES);

    AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_chg |-> int'(level_o) <= cap_now);                                   // R2
    AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && full_o && !rd_i && !mode_chg) |=> overrun_o);              // R6
    AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && full_o && !rd_i && !mode_chg) |=> level_o == $past(level_o)); // R6
    AST_SWAP_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && rd_i && full_o && !empty_o && !mode_chg && !overrun_o)
        |=> (level_o == $past(level_o)) && !overrun_o);                           // R7
    AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && empty_o) |=> $stable(rd_data_o));                                // R8
    AST_DMA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o |-> !dma_req_o);                                                  // R9
    AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg |=> (level_o == '0) && !overrun_o);                              // R10
endmodule

bind spi_rx_buffer spi_rxb_checker #(.BYTES(BYTES), .LVL_W(LVL_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .wide_i     (wide_i),
    .rx_valid_i (rx_valid_i),
    .rd_i       (rd_i),
    .ovr_clr_i  (ovr_clr_i),
    .rd_data_o  (rd_data_o),
    .level_o    (level_o),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .overrun_o  (overrun_o),
    .dma_req_o  (dma_req_o)
);

// File: tb/spi_rx_buffer_tb.sv
`timescale 1ns/1ps
module spi_rx_buffer_tb_top;
    localparam int BYTES = 8;
    localparam int LVL_W = $clog2(BYTES) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fe = 1'b0, wd = 1'b0, de = 1'b0, v = 1'b0, r = 1'b0, clr = 1'b0;
    logic [15:0]      d = '0;
    logic [15:0]      rd_data;
    logic [LVL_W-1:0] level;
    logic             empty, full, ovr, dreq;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [15:0] mq[$];
    logic        m_fe = 1'b0, m_wd = 1'b0, m_ovr = 1'b0;
    logic [15:0] m_rd = '0;

    always #2.5 clk = ~clk;

    spi_rx_buffer #(.BYTES(BYTES), .LVL_W(LVL_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fe), .wide_i(wd), .dma_en_i(de),
        .rx_valid_i(v), .rx_data_i(d), .rd_i(r), .ovr_clr_i(clr),
        .rd_data_o(rd_data), .level_o(level), .empty_o(empty), .full_o(full),
        .overrun_o(ovr), .dma_req_o(dreq)
    );

    function automatic int depth_of(logic f, logic w);
        if (!f) return 1;
        return w ? 4 : 8;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit popok, pushok;
        if (fe != m_fe || wd != m_wd) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            popok  = r && mq.size() > 0;
            pushok = v && (mq.size() < depth_of(fe, wd) || popok);
            if (popok) m_rd = mq.pop_front();
            if (pushok) mq.push_back(wd ? d : {8'h00, d[7:0]});
            if (clr) m_ovr = 1'b0;
            if (v && !pushok) m_ovr = 1'b1;
        end
        m_fe = fe;
        m_wd = wd;
    endtask

    task automatic compare(string req);
        chk(req, "level", int'(level), mq.size());
        chk(req, "empty", int'(empty), int'(mq.size() == 0));
        chk(req, "full", int'(full), int'(mq.size() >= depth_of(fe, wd)));
        chk(req, "overrun", int'(ovr), int'(m_ovr));
        chk(req, "rd_data", int'(rd_data), int'(m_rd));
        chk("R9", "dma_req", int'(dreq), int'(de && mq.size() > 0));
    endtask

    task automatic step(logic f, logic w, logic e, logic vv, logic [15:0] dd,
                        logic rr, logic cc, string req);
        fe = f; wd = w; de = e; v = vv; d = dd; r = rr; clr = cc;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "level", int'(level), 0);
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "flags", int'({full, ovr, dreq}), 0);
        chk("R1", "rd_data", int'(rd_data), 0);

        // R2 8-bit FIFO: fill, overfill, drain
        step(1, 0, 1, 0, 0, 0, 0, "R10");
        for (int i = 0; i < 8; i++) step(1, 0, 1, 1, 16'hA500 + 16'(i * 17), 0, 0, "R2");
        step(1, 0, 1, 1, 16'h00EE, 0, 0, "R6");
        step(1, 0, 1, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 0, 1, 0, "R5");
        step(1, 0, 1, 0, 0, 1, 0, "R8");
        step(1, 0, 1, 0, 0, 1, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 1, "R6");

        // R3 16-bit FIFO after a flush with data held
        step(1, 0, 0, 1, 16'h1234, 0, 0, "R2");
        step(1, 1, 1, 1, 16'h5678, 1, 0, "R10");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 16'hBEE0 + 16'(i), 0, 0, "R3");
        step(1, 1, 1, 1, 16'hDEAD, 0, 0, "R6");
        step(1, 1, 1, 1, 16'hCAFE, 0, 1, "R6");
        step(1, 1, 1, 0, 0, 0, 1, "R6");
        step(1, 1, 1, 1, 16'hF00D, 1, 0, "R7");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 0, 1, 0, "R3");

        // R4 single-entry mode
        step(0, 1, 1, 0, 0, 0, 0, "R10");
        step(0, 1, 1, 1, 16'h7A7A, 0, 0, "R4");
        step(0, 1, 1, 1, 16'h0101, 0, 0, "R4");
        step(0, 1, 1, 1, 16'h0202, 1, 0, "R7");
        step(0, 1, 1, 0, 0, 1, 0, "R5");
        step(0, 0, 1, 1, 16'h3333, 0, 0, "R10");
        step(0, 0, 1, 1, 16'h3344, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 1, 0, "R5");

        // seeded random mix
        for (int n = 0; n < 4000; n++) begin
            logic nf, nw;
            nf = ($urandom % 64 == 0) ? ~fe : fe;
            nw = ($urandom % 64 == 0) ? ~wd : wd;
            step(nf, nw, 1'($urandom % 4 != 0), 1'($urandom % 2), 16'($urandom),
                 1'($urandom % 3 == 0), 1'($urandom % 16 == 0), "R2");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule